// File: doc/BRIEF.md
# Dual-path reset controller

This block turns one external active-low reset pin into the reset signals a clock domain needs. It drives an asynchronous reset for the flops' clear inputs and a synchronous reset for their data paths. It also drives a set of leaf resets that reach the far end of the domain through registered distribution stages. The asynchronous and synchronous resets are separate paths. This lets flops leave their asynchronous clear well before any data path can present a one to them. Recovery and removal margins therefore hold even when reset takes several clock cycles to cross the die.

Two modes are selected by `mode_i`. In dual mode (`mode_i` = 0) the asynchronous reset is the pin itself, for both assertion and release. The synchronous reset is held for a programmable number of clock edges after release. In synchronized mode (`mode_i` = 1) the asynchronous reset still asserts at once, but its release passes through a flop chain and lands on a clock edge. The delay count then starts from that aligned release. In both modes the synchronous reset feeds a cascade of register stages, so that each stage has a limited fanout. `mode_i` and `delay_i` are static configuration, changed only while the pin is held low.

Top module: `rst_ctrl`

## Requirements
- R1: With `mode_i` = 0, `arst_no` equals `rst_ni` at all times, with no clock edge involved in either direction.
- R2: While `rst_ni` is low, `srst_no` and every bit of `leaf_rst_no` are low in both modes, and they go low without waiting for a clock edge.
- R3: With `mode_i` = 0 and N = `delay_i`, `srst_no` goes high on rising edge max(N,1) after `rst_ni` goes high, where the first rising edge after the pin release is edge 1.
- R4: If `rst_ni` falls again before the count ends, the count restarts. After the final release, `srst_no` is held for the full length again, even for a pin pulse shorter than one clock period.
- R5: With `mode_i` = 1, `arst_no` falls with `rst_ni` asynchronously and rises on rising edge SYNC_STAGES after the pin release.
- R6: With `mode_i` = 1, `srst_no` rises on edge SYNC_STAGES + max(N,1). In both modes `srst_no` is never high while `arst_no` is low.
- R7: All bits of `leaf_rst_no` rise on the same rising edge, exactly CASCADE_DEPTH edges after `srst_no` rises.
- R8: Once released, every output stays high for as long as `rst_ni` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Domain clock |
| rst_ni | input | 1 | External reset pin, active low, asynchronous |
| mode_i | input | 1 | 0 = dual path, 1 = synchronized release |
| delay_i | input | CNT_W | Number of edges the synchronous reset is held after release |
| arst_no | output | 1 | Asynchronous reset for flop clear inputs, active low |
| srst_no | output | 1 | Synchronous data-path reset, active low |
| leaf_rst_no | output | NUM_LEAVES | Cascaded synchronous resets, active low |

## Verification
The bench builds the block with SYNC_STAGES = 3, CNT_W = 4, CASCADE_DEPTH = 2 and NUM_LEAVES = 5. A three-flop chain tells the synchronizer latency apart from the two-stage cascade latency. The four-bit delay reaches its top value of 15 as well as the zero and one corners, which both give a one-edge hold. Five leaves give an uneven split at the middle stage of the tree, so a wrong source index would show up as one leaf releasing late. The pin is released at several offsets within the clock period. Each release edge is counted from the first edge after the pin goes high.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;

  typedef enum logic {
    MODE_DUAL = 1'b0,
    MODE_SYNC = 1'b1
  } rst_mode_e;

  // width of cascade stage d out of depth stages feeding leaves outputs
  function automatic int stage_w(input int d, input int depth, input int leaves);
    int w;
    w = leaves;
    for (int j = d; j < depth - 1; j++) w = (w + 1) / 2;
    if (w < 1) w = 1;
    return w;
  endfunction

endpackage

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rel_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rel_o = chain_q[STAGES-1];

endmodule

// File: rtl/rst_delay_cnt.sv
module rst_delay_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             arst_ni,
  input  logic [CNT_W-1:0] delay_i,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  // re-assertion clears the count, so short pulses still get a full hold
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_inc[CNT_W-1:0];
      if (cnt_inc >= {1'b0, delay_i}) done_q <= 1'b1;
    end
  end

  assign done_o = done_q;

endmodule

// File: rtl/rst_fanout_tree.sv
module rst_fanout_tree
  import rst_ctrl_pkg::*;
#(
  parameter int DEPTH  = 2,
  parameter int LEAVES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_i,
  output logic [LEAVES-1:0] leaf_o
);

  for (genvar d = 0; d < DEPTH; d++) begin : g_stg
    localparam int W  = stage_w(d, DEPTH, LEAVES);
    localparam int WP = (d == 0) ? 1 : stage_w(d - 1, DEPTH, LEAVES);

    logic [W-1:0]  q;
    logic [W-1:0]  nxt;
    logic [WP-1:0] prev;

    if (d == 0) begin : g_root
      assign prev = src_i;
    end else begin : g_inner
      assign prev = g_stg[d-1].q;
    end

    always_comb begin
      for (int i = 0; i < W; i++) nxt[i] = prev[(i * WP) / W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= nxt;
    end
  end

  assign leaf_o = g_stg[DEPTH-1].q;

endmodule

// File: rtl/rst_ctrl.sv
module rst_ctrl
  import rst_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int CNT_W         = 8,
  parameter int CASCADE_DEPTH = 2,
  parameter int NUM_LEAVES    = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mode_i,
  input  logic [CNT_W-1:0]      delay_i,
  output logic                  arst_no,
  output logic                  srst_no,
  output logic [NUM_LEAVES-1:0] leaf_rst_no
);

  logic sync_rel;
  logic cnt_done;

  rst_release_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rel_o (sync_rel)
  );

  // dual mode: pin drives clears directly; sync mode: aligned release
  assign arst_no = (rst_mode_e'(mode_i) == MODE_SYNC) ? sync_rel : rst_ni;

  rst_delay_cnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i  (clk_i),
    .arst_ni(arst_no),
    .delay_i(delay_i),
    .done_o (cnt_done)
  );

  assign srst_no = cnt_done;

  rst_fanout_tree #(
    .DEPTH (CASCADE_DEPTH),
    .LEAVES(NUM_LEAVES)
  ) u_tree (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (cnt_done),
    .leaf_o(leaf_rst_no)
  );

endmodule

// File: rtl/rst_ctrl_chk.sv
module rst_ctrl_chk #(
  parameter int NUM_LEAVES = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  mode_i,
  input logic                  arst_no,
  input logic                  srst_no,
  input logic [NUM_LEAVES-1:0] leaf_rst_no
);

  p_arst_follows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |-> arst_no);

  p_sync_on_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && $rose(arst_no)) |-> $past(rst_ni));

  p_srst_after_arst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_no |-> arst_no);

  p_leaf_aligned_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(leaf_rst_no) == 0) || ($countones(leaf_rst_no) == NUM_LEAVES));

  p_leaf_after_srst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(leaf_rst_no[0]) |-> srst_no);

  p_srst_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_no |=> srst_no);

  p_leaf_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leaf_rst_no[0] |=> leaf_rst_no[0]);

endmodule

bind rst_ctrl rst_ctrl_chk #(
  .NUM_LEAVES(NUM_LEAVES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .arst_no    (arst_no),
  .srst_no    (srst_no),
  .leaf_rst_no(leaf_rst_no)
);

// File: tb/rst_ctrl_tb.sv
`timescale 1ns/1ps
module rst_ctrl_tb;

  localparam int S = 3;
  localparam int CW = 4;
  localparam int D = 2;
  localparam int L = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode = 1'b0;
  logic [CW-1:0] dly = '0;
  logic          arst_n, srst_n;
  logic [L-1:0]  leaf_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rst_ctrl #(
    .SYNC_STAGES(S), .CNT_W(CW), .CASCADE_DEPTH(D), .NUM_LEAVES(L)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .delay_i(dly),
    .arst_no(arst_n), .srst_no(srst_n), .leaf_rst_no(leaf_n)
  );

  // {mode, delay, release offset in units of 0.5 ns (1..9)}
  localparam logic [8:0] VEC [8] = '{
    {1'b0, 4'd0,  4'd1},
    {1'b0, 4'd1,  4'd3},
    {1'b0, 4'd5,  4'd8},
    {1'b0, 4'd15, 4'd5},
    {1'b1, 4'd0,  4'd2},
    {1'b1, 4'd1,  4'd9},
    {1'b1, 4'd6,  4'd4},
    {1'b1, 4'd15, 4'd7}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic int maxn1(input int n);
    return (n < 1) ? 1 : n;
  endfunction

  // hold pin low, check reset state, set config
  task automatic enter_reset(input logic m, input logic [CW-1:0] n);
    @(posedge clk); #1.3;
    rst_n = 1'b0;
    #0.2;
    chk(srst_n == 1'b0, "R2 srst async", int'(srst_n), 0);
    chk(leaf_n == '0, "R2 leaves async", int'(leaf_n), 0);
    chk(arst_n == 1'b0, "R1/R5 arst async", int'(arst_n), 0);
    mode = m;
    dly  = n;
    repeat (3) @(posedge clk);
  endtask

  // release at offset, measure edge numbers of each output release
  task automatic release_and_measure(input logic m, input int n, input int off_half);
    int a_k, s_k, l_k, ea, es, el;
    a_k = 0; s_k = 0; l_k = 0;
    @(posedge clk);
    #(off_half * 0.5);
    rst_n = 1'b1;
    #0.05;
    if (m == 1'b0) chk(arst_n == 1'b1, "R1 arst follows pin release", int'(arst_n), 1);
    else           chk(arst_n == 1'b0, "R5 arst held until edge", int'(arst_n), 0);
    for (int k = 1; k <= 30; k++) begin
      @(posedge clk); #1;
      if (arst_n && a_k == 0) a_k = k;
      if (srst_n && s_k == 0) s_k = k;
      if (leaf_n == '1 && l_k == 0) l_k = k;
      if (leaf_n != '0 && leaf_n != '1)
        chk(1'b0, "R7 leaves split", int'(leaf_n), 0);
    end
    ea = (m == 1'b0) ? 0 : S;
    es = ((m == 1'b0) ? 0 : S) + maxn1(n);
    el = es + D;
    if (m == 1'b1) chk(a_k == ea, "R5 arst release edge", a_k, ea);
    if (m == 1'b0) chk(s_k == es, "R3 srst release edge", s_k, es);
    else           chk(s_k == es, "R6 srst release edge", s_k, es);
    chk(l_k == el, "R7 leaf release edge", l_k, el);
    chk(arst_n && srst_n && leaf_n == '1, "R8 outputs stay released",
        int'({arst_n, srst_n}), 3);
  endtask

  initial begin
    #200000;
    chk(1'b0, "watchdog", 0, 1);
    finish_sim();
  end

  initial begin
    #1;
    chk(arst_n == 1'b0 && srst_n == 1'b0 && leaf_n == '0, "R2 reset state",
        int'({arst_n, srst_n}), 0);
    repeat (3) @(posedge clk);

    for (int i = 0; i < 8; i++) begin
      enter_reset(VEC[i][8], VEC[i][7:4]);
      release_and_measure(VEC[i][8], int'(VEC[i][7:4]), int'(VEC[i][3:0]));
    end

    // R4: re-assert mid-count in dual mode, full hold again
    enter_reset(1'b0, 4'd6);
    @(posedge clk); #2.0;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(srst_n == 1'b0, "R4 still held before reassert", int'(srst_n), 0);
    rst_n = 1'b0;
    #0.2;
    chk(srst_n == 1'b0 && leaf_n == '0, "R2 reassert mid-count", int'(srst_n), 0);
    release_and_measure(1'b0, 6, 6);

    // R4: glitch shorter than a clock period after full release
    @(posedge clk); #1.0;
    rst_n = 1'b0;
    #0.3;
    chk(arst_n == 1'b0 && srst_n == 1'b0, "R4 glitch asserts", int'({arst_n, srst_n}), 0);
    #1.0;
    release_and_measure(1'b0, 6, 1);

    // R4 in synchronized mode with a mid-count reassert
    enter_reset(1'b1, 4'd4);
    @(posedge clk); #3.0;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(arst_n == 1'b1 && srst_n == 1'b0, "R4 sync mode mid-count", int'({arst_n, srst_n}), 2);
    rst_n = 1'b0;
    #0.2;
    release_and_measure(1'b1, 4, 3);

    repeat (5) @(posedge clk);
    finish_sim();
  end

endmodule